// File: doc/BRIEF.md
# Two-Core Atomic Read-Modify-Write Unit

This unit sits on the memory side of a small shared word store and serves two cores. Each core has two paths into it. The plain path carries ordinary aligned word loads and stores, and needs no lock. The locked path carries an atomic operation: a bit set or clear with the old bit returned as a carry, a decrement or increment with the sign of the result returned, or a swap that returns the previous contents. A locked operation reads the addressed word, changes it and writes it back in a single cycle. No other access can touch the store in that cycle.

A core that wins the lock owns the whole store until release. During that time the other core's plain accesses are held off with a stall and wait. After the write-back, the unit does not release the lock until the owning core reports that its store buffer is empty. During this drain window the owner may still push its buffered stores through its plain path. So every locked operation also acts as a full ordering fence for the owner. When both cores ask for the lock in the same cycle, the grant alternates between them, and core 0 goes first after reset.

Top module: `atomic_rmw_unit`

## Requirements
- R1: With no lock held, a plain access from a single core is never stalled. A write is in the store after the clock edge that accepts it. Read data appears on that core's `pl_rdata` in the cycle after acceptance, and holds until that core's next accepted read.
- R2: With no lock held, if both cores present plain accesses in the same cycle, core 0 is served and core 1 sees `pl_stall[1]` high. Core 1's access has no effect until it is served.
- R3: When both cores request the lock in the same cycle, the winner is the core that did not win the previous grant. The first grant after reset goes to core 0.
- R4: `lk_gnt[c]` is high for exactly one cycle, in the cycle after the lock was free and core c's request was taken. The requester holds `lk_req[c]` until it sees the grant. If the store buffer is already empty, `lk_done[c]` is high for exactly one cycle, two cycles after the grant.
- R5: From the grant cycle up to, but not including, the done cycle, every plain access by the non-owning core is stalled. A stalled read that is later served returns the word as left by the locked operation.
- R6: The lock is released only after `sb_empty` of the owner has been seen high in the drain phase. `lk_done` follows one cycle after that. The owner's plain accesses are stalled in the execute cycle (the grant cycle) and are served in the drain phase.
- R7: Op code 0 (bit set) returns the old value of bit `lk_bit` on `lk_cf` and writes the word back with that bit set to 1. `lk_sf` is 0.
- R8: Op code 1 (bit clear) returns the old value of bit `lk_bit` on `lk_cf` and writes the word back with that bit cleared to 0. `lk_sf` is 0.
- R9: Op code 2 (decrement) writes back the old value minus one, modulo 2^32. `lk_sf` carries bit 31 of the result and `lk_cf` is 0.
- R10: Op code 3 (increment) writes back the old value plus one, modulo 2^32. `lk_sf` carries bit 31 of the result and `lk_cf` is 0.
- R11: Op code 4 (swap) writes `lk_wdata` and returns the prior word. `lk_cf` and `lk_sf` are 0.
- R12: Op codes 5, 6 and 7 complete the normal handshake, leave the word unchanged, and return 0 on `lk_cf` and `lk_sf`.
- R13: For every op, `lk_old` in the done cycle is the word's value just before the operation. After reset, all words read 0, and `lk_gnt`, `lk_done` and `pl_stall` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 2 | Per-core lock request, held until grant |
| lk_op | input | 2x3 | Per-core operation code |
| lk_addr | input | 2x4 | Per-core word address of the locked operation |
| lk_bit | input | 2x5 | Per-core bit index for bit set or clear |
| lk_wdata | input | 2x32 | Per-core value for swap |
| sb_empty | input | 2 | Per-core store buffer empty indication |
| lk_gnt | output | 2 | One-cycle grant pulse per core |
| lk_done | output | 2 | One-cycle completion pulse per core |
| lk_old | output | 32 | Word value before the operation, valid with done |
| lk_cf | output | 1 | Old selected bit for the bit operations |
| lk_sf | output | 1 | Sign of the result for decrement or increment |
| pl_vld | input | 2 | Per-core plain access valid, held while stalled |
| pl_we | input | 2 | Per-core plain write enable |
| pl_addr | input | 2x4 | Per-core plain word address |
| pl_wdata | input | 2x32 | Per-core plain write data |
| pl_stall | output | 2 | Per-core stall of the plain access |
| pl_rdata | output | 2x32 | Per-core registered plain read data |

## Verification
The bench goes after the arbitration corner cases first. It sends simultaneous lock requests right after reset and again after a single-core grant. A fixed-priority arbiter would hand core 0 both of those grants. It holds a core's store buffer non-empty across several cycles: a unit that released on write-back alone would pulse done early and let the other core's stalled read slip in with the pre-lock word. It walks decrement and increment across zero and across the sign boundary, and runs bit operations on bits that are already set or clear. An off-by-one flag or a result taken from the wrong side of the operation shows up as a wrong carry, sign or old value. Unused op codes and same-cycle plain contention check that nothing is written when nothing should be.

// File: rtl/atomic_rmw_pkg.sv
// Shared types of the atomic read-modify-write unit.
// Assumes: exactly two requesting cores; op codes fixed at three bits.
package atomic_rmw_pkg;

    typedef enum logic [2:0] {
        OP_BSET = 3'd0,
        OP_BCLR = 3'd1,
        OP_DEC  = 3'd2,
        OP_INC  = 3'd3,
        OP_SWAP = 3'd4
    } rmw_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EXEC  = 2'd1,
        ST_DRAIN = 2'd2
    } lock_state_e;

endpackage

// File: rtl/atomic_rr_arb.sv
// Two-way round-robin arbiter for lock requests.
// Does: picks a winner among the requests; on a tie, picks the core that
// did not win last time. Assumes: 'take' is high only when the lock is free,
// and the winner is consumed in the same cycle.
module atomic_rr_arb (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    input  logic       take,
    output logic       win_vld,
    output logic       win_id
);
    logic last_q;

    // Winner selection: alternate on a tie, otherwise the sole requester.
    always_comb begin
        win_vld = |req;
        win_id  = (req == 2'b11) ? ~last_q : ~req[0];
    end

    // Remember the last winner; reset value makes core 0 first.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= 1'b1;
        else if (take && win_vld)
            last_q <= win_id;
    end

    p_tie_alternates_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req == 2'b11) |=> (last_q != $past(last_q)));

endmodule

// File: rtl/atomic_rmw_alu.sv
// Combinational modify stage of a locked operation.
// Does: computes the value to write back and the carry and sign flags from
// the old word. Assumes: op codes outside the defined set leave the word as is.
module atomic_rmw_alu
    import atomic_rmw_pkg::*;
#(
    parameter int DW = 32,
    parameter int BW = $clog2(DW)
) (
    input  logic [2:0]    op,
    input  logic [BW-1:0] bit_idx,
    input  logic [DW-1:0] old_word,
    input  logic [DW-1:0] swap_val,
    output logic [DW-1:0] new_word,
    output logic          cf,
    output logic          sf
);
    logic [DW-1:0] mask;

    // Build the result and flags for the requested operation.
    always_comb begin
        mask     = {{(DW-1){1'b0}}, 1'b1} << bit_idx;
        new_word = old_word;
        cf       = 1'b0;
        sf       = 1'b0;
        case (op)
            OP_BSET: begin
                cf       = old_word[bit_idx];
                new_word = old_word | mask;
            end
            OP_BCLR: begin
                cf       = old_word[bit_idx];
                new_word = old_word & ~mask;
            end
            OP_DEC: begin
                new_word = old_word - {{(DW-1){1'b0}}, 1'b1};
                sf       = new_word[DW-1];
            end
            OP_INC: begin
                new_word = old_word + {{(DW-1){1'b0}}, 1'b1};
                sf       = new_word[DW-1];
            end
            OP_SWAP: new_word = swap_val;
            default: new_word = old_word;
        endcase
    end

endmodule

// File: rtl/atomic_word_mem.sv
// Word store with one locked port and one plain port.
// Does: the locked port reads combinationally and writes at the edge; the
// plain port reads combinationally and writes at the edge. Assumes: the two
// writers are never active in the same cycle (the controller guarantees it).
module atomic_word_mem #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] lk_addr,
    input  logic          lk_we,
    input  logic [DW-1:0] lk_wdata,
    output logic [DW-1:0] lk_rdata,
    input  logic [AW-1:0] p_addr,
    input  logic          p_we,
    input  logic [DW-1:0] p_wdata,
    output logic [DW-1:0] p_rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Combinational read for both ports.
    always_comb begin
        lk_rdata = mem[lk_addr];
        p_rdata  = mem[p_addr];
    end

    // Clear on reset, then accept whichever single writer is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (lk_we) begin
            mem[lk_addr] <= lk_wdata;
        end else if (p_we) begin
            mem[p_addr] <= p_wdata;
        end
    end

    p_single_writer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_we && p_we));

endmodule

// File: rtl/atomic_lock_ctrl.sv
// Lock sequencer: idle, execute, drain.
// Does: captures the winning command, performs the write-back in the execute
// cycle, holds the lock until the owner's store buffer is empty, then pulses
// done with the latched old value and flags. Assumes: requesters hold their
// request until they see the grant.
module atomic_lock_ctrl
    import atomic_rmw_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 4,
    parameter int BW = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                win_vld,
    input  logic                win_id,
    input  logic [1:0][2:0]     lk_op,
    input  logic [1:0][AW-1:0]  lk_addr,
    input  logic [1:0][BW-1:0]  lk_bit,
    input  logic [1:0][DW-1:0]  lk_wdata,
    input  logic [1:0]          sb_empty,
    input  logic [DW-1:0]       mem_rdata,
    input  logic                alu_cf,
    input  logic                alu_sf,
    output logic                idle,
    output logic                locked,
    output logic                draining,
    output logic                owner,
    output logic                mem_we,
    output logic [AW-1:0]       cmd_addr,
    output logic [2:0]          cmd_op,
    output logic [BW-1:0]       cmd_bit,
    output logic [DW-1:0]       cmd_wdata,
    output logic [1:0]          gnt,
    output logic [1:0]          done,
    output logic [DW-1:0]       old_q,
    output logic                cf_q,
    output logic                sf_q
);
    lock_state_e state;

    // Status decode of the sequencer state.
    always_comb begin
        idle     = (state == ST_IDLE);
        locked   = (state != ST_IDLE);
        draining = (state == ST_DRAIN);
        mem_we   = (state == ST_EXEC);
    end

    // Sequencer, command capture and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            owner     <= 1'b0;
            cmd_addr  <= '0;
            cmd_op    <= '0;
            cmd_bit   <= '0;
            cmd_wdata <= '0;
            gnt       <= '0;
            done      <= '0;
            old_q     <= '0;
            cf_q      <= 1'b0;
            sf_q      <= 1'b0;
        end else begin
            gnt  <= '0;
            done <= '0;
            case (state)
                ST_IDLE: begin
                    if (win_vld) begin
                        owner     <= win_id;
                        cmd_addr  <= lk_addr[win_id];
                        cmd_op    <= lk_op[win_id];
                        cmd_bit   <= lk_bit[win_id];
                        cmd_wdata <= lk_wdata[win_id];
                        gnt       <= win_id ? 2'b10 : 2'b01;
                        state     <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    old_q <= mem_rdata;
                    cf_q  <= alu_cf;
                    sf_q  <= alu_sf;
                    state <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (sb_empty[owner]) begin
                        done  <= owner ? 2'b10 : 2'b01;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_gnt_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    p_gnt_in_exec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != 2'b00) |-> (state == ST_EXEC));
    p_exec_then_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC) |=> (state == ST_DRAIN));
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done != 2'b00) |=> (done == 2'b00));
    p_hold_until_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && !sb_empty[owner]) |=> (state == ST_DRAIN && done == 2'b00));

endmodule

// File: rtl/atomic_rmw_unit.sv
// Top of the two-core atomic read-modify-write unit.
// Does: arbitrates the lock, runs the locked operation on the word store,
// and gates the plain paths: the non-owner is stalled for the whole lock,
// the owner only in the execute cycle; with no lock, core 0 has the plain
// path when both ask. Assumes: a stalled plain access is held by its core.
module atomic_rmw_unit
    import atomic_rmw_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int BW    = $clog2(DW)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         lk_req,
    input  logic [1:0][2:0]    lk_op,
    input  logic [1:0][AW-1:0] lk_addr,
    input  logic [1:0][BW-1:0] lk_bit,
    input  logic [1:0][DW-1:0] lk_wdata,
    input  logic [1:0]         sb_empty,
    output logic [1:0]         lk_gnt,
    output logic [1:0]         lk_done,
    output logic [DW-1:0]      lk_old,
    output logic               lk_cf,
    output logic               lk_sf,
    input  logic [1:0]         pl_vld,
    input  logic [1:0]         pl_we,
    input  logic [1:0][AW-1:0] pl_addr,
    input  logic [1:0][DW-1:0] pl_wdata,
    output logic [1:0]         pl_stall,
    output logic [1:0][DW-1:0] pl_rdata
);
    logic          idle, locked, draining, owner, mem_we;
    logic          win_vld, win_id;
    logic [AW-1:0] cmd_addr;
    logic [2:0]    cmd_op;
    logic [BW-1:0] cmd_bit;
    logic [DW-1:0] cmd_wdata;
    logic [DW-1:0] lk_rdata, alu_new, p_rdata;
    logic          alu_cf, alu_sf;
    logic [1:0]    blk, served;
    logic          p_sel, p_we;
    logic          other;

    atomic_rr_arb u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (lk_req),
        .take    (idle),
        .win_vld (win_vld),
        .win_id  (win_id)
    );

    atomic_lock_ctrl #(.DW(DW), .AW(AW), .BW(BW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_vld   (win_vld),
        .win_id    (win_id),
        .lk_op     (lk_op),
        .lk_addr   (lk_addr),
        .lk_bit    (lk_bit),
        .lk_wdata  (lk_wdata),
        .sb_empty  (sb_empty),
        .mem_rdata (lk_rdata),
        .alu_cf    (alu_cf),
        .alu_sf    (alu_sf),
        .idle      (idle),
        .locked    (locked),
        .draining  (draining),
        .owner     (owner),
        .mem_we    (mem_we),
        .cmd_addr  (cmd_addr),
        .cmd_op    (cmd_op),
        .cmd_bit   (cmd_bit),
        .cmd_wdata (cmd_wdata),
        .gnt       (lk_gnt),
        .done      (lk_done),
        .old_q     (lk_old),
        .cf_q      (lk_cf),
        .sf_q      (lk_sf)
    );

    atomic_rmw_alu #(.DW(DW), .BW(BW)) u_alu (
        .op       (cmd_op),
        .bit_idx  (cmd_bit),
        .old_word (lk_rdata),
        .swap_val (cmd_wdata),
        .new_word (alu_new),
        .cf       (alu_cf),
        .sf       (alu_sf)
    );

    // Per-core lock blocking: only the owner in its drain phase passes.
    for (genvar i = 0; i < 2; i++) begin : g_blk
        always_comb blk[i] = locked && !(draining && (owner == 1'(i)));
    end

    // Plain-path gating: core 0 before core 1 when both are unblocked.
    always_comb begin
        other       = ~owner;
        served[0]   = pl_vld[0] && !blk[0];
        pl_stall[0] = pl_vld[0] &&  blk[0];
        served[1]   = pl_vld[1] && !(blk[1] || served[0]);
        pl_stall[1] = pl_vld[1] &&  (blk[1] || served[0]);
        p_sel       = !served[0];
        p_we        = (served[0] && pl_we[0]) || (served[1] && pl_we[1]);
    end

    atomic_word_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_addr  (cmd_addr),
        .lk_we    (mem_we),
        .lk_wdata (alu_new),
        .lk_rdata (lk_rdata),
        .p_addr   (pl_addr[p_sel]),
        .p_we     (p_we),
        .p_wdata  (pl_wdata[p_sel]),
        .p_rdata  (p_rdata)
    );

    // Per-core read data register, loaded by that core's served read.
    for (genvar i = 0; i < 2; i++) begin : g_rd
        always_ff @(posedge clk) begin
            if (!rst_n)
                pl_rdata[i] <= '0;
            else if (served[i] && !pl_we[i])
                pl_rdata[i] <= p_rdata;
        end
    end

    p_other_stalled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && pl_vld[other]) |-> pl_stall[other]);
    p_plain_conflict_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && pl_vld == 2'b11) |-> (pl_stall == 2'b10));
    p_free_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !(pl_vld == 2'b11)) |-> (pl_stall == 2'b00));

endmodule

// File: tb/atomic_rmw_unit_tb.sv
// Directed bench for the two-core atomic read-modify-write unit.
module atomic_rmw_unit_tb;
    localparam int DW = 32;
    localparam int DEPTH = 16;
    localparam int AW = 4;
    localparam int BW = 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [1:0]         lk_req = '0;
    logic [1:0][2:0]    lk_op = '0;
    logic [1:0][AW-1:0] lk_addr = '0;
    logic [1:0][BW-1:0] lk_bit = '0;
    logic [1:0][DW-1:0] lk_wdata = '0;
    logic [1:0]         sb_empty = 2'b11;
    logic [1:0]         lk_gnt, lk_done;
    logic [DW-1:0]      lk_old;
    logic               lk_cf, lk_sf;
    logic [1:0]         pl_vld = '0;
    logic [1:0]         pl_we = '0;
    logic [1:0][AW-1:0] pl_addr = '0;
    logic [1:0][DW-1:0] pl_wdata = '0;
    logic [1:0]         pl_stall;
    logic [1:0][DW-1:0] pl_rdata;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    atomic_rmw_unit #(.DW(DW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_op(lk_op), .lk_addr(lk_addr), .lk_bit(lk_bit),
        .lk_wdata(lk_wdata), .sb_empty(sb_empty),
        .lk_gnt(lk_gnt), .lk_done(lk_done), .lk_old(lk_old),
        .lk_cf(lk_cf), .lk_sf(lk_sf),
        .pl_vld(pl_vld), .pl_we(pl_we), .pl_addr(pl_addr), .pl_wdata(pl_wdata),
        .pl_stall(pl_stall), .pl_rdata(pl_rdata)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic plain_wr(input int c, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        pl_vld[c] = 1'b1; pl_we[c] = 1'b1; pl_addr[c] = a; pl_wdata[c] = d;
        @(negedge clk);
        pl_vld[c] = 1'b0; pl_we[c] = 1'b0;
    endtask

    task automatic plain_rd(input int c, input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        pl_vld[c] = 1'b1; pl_we[c] = 1'b0; pl_addr[c] = a;
        @(negedge clk);
        pl_vld[c] = 1'b0;
        d = pl_rdata[c];
    endtask

    task automatic wait_gnt(input int c, output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!lk_gnt[c] && n < 50);
        lk_req[c] = 1'b0;
    endtask

    task automatic wait_done(input int c, output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!lk_done[c] && n < 50);
    endtask

    // Full locked operation with handshake timing checks (R4).
    task automatic lock_op(input int c, input logic [2:0] op, input logic [AW-1:0] a,
                           input logic [BW-1:0] b, input logic [DW-1:0] wd,
                           output logic [DW-1:0] old, output logic cf, output logic sf);
        int n;
        @(negedge clk);
        lk_req[c] = 1'b1; lk_op[c] = op; lk_addr[c] = a; lk_bit[c] = b; lk_wdata[c] = wd;
        wait_gnt(c, n);
        chk("R4 grant one cycle after request", n, 1);
        wait_done(c, n);
        chk("R4 done two cycles after grant", n, 2);
        old = lk_old; cf = lk_cf; sf = lk_sf;
        @(negedge clk);
        chk("R4 done lasts one cycle", lk_done, 0);
    endtask

    task automatic t_reset();
        logic [DW-1:0] d;
        chk("R13 reset grant", lk_gnt, 0);
        chk("R13 reset done", lk_done, 0);
        chk("R13 reset stall", pl_stall, 0);
        plain_rd(0, 4'd9, d);
        chk("R13 reset word zero", d, 0);
    endtask

    task automatic t_plain();
        logic [DW-1:0] d;
        plain_wr(1, 4'd1, 32'hCAFE_0001);
        plain_rd(0, 4'd1, d);
        chk("R1 plain write then read", d, 32'hCAFE_0001);
        @(negedge clk);
        chk("R1 read data holds", pl_rdata[0], 32'hCAFE_0001);
        // Same-cycle contention (R2).
        @(negedge clk);
        pl_vld = 2'b11; pl_we = 2'b11;
        pl_addr[0] = 4'd10; pl_wdata[0] = 32'h1111_0000;
        pl_addr[1] = 4'd11; pl_wdata[1] = 32'h2222_0000;
        #1;
        chk("R2 contention stalls core 1 only", pl_stall, 2'b10);
        @(negedge clk);
        pl_vld = 2'b00; pl_we = 2'b00;
        plain_rd(0, 4'd11, d);
        chk("R2 stalled write left no trace", d, 0);
        plain_rd(0, 4'd10, d);
        chk("R2 core 0 write landed", d, 32'h1111_0000);
    endtask

    task automatic t_rr();
        int n;
        logic [DW-1:0] o; logic cf, sf;
        @(negedge clk);
        lk_req = 2'b11; lk_op = '0; lk_addr[0] = 4'd12; lk_addr[1] = 4'd13; lk_bit = '0;
        @(negedge clk);
        chk("R3 first tie after reset to core 0", lk_gnt, 2'b01);
        lk_req[0] = 1'b0;
        wait_done(0, n);
        wait_gnt(1, n);
        chk("R3 waiting core 1 served next", n, 1);
        wait_done(1, n);
        // Core 1 won last: tie goes to core 0.
        @(negedge clk);
        lk_req = 2'b11;
        @(negedge clk);
        chk("R3 tie after core 1 goes to core 0", lk_gnt, 2'b01);
        lk_req[0] = 1'b0;
        wait_done(0, n);
        wait_gnt(1, n);
        wait_done(1, n);
        lock_op(0, 3'd0, 4'd14, 5'd0, '0, o, cf, sf);
        @(negedge clk);
        lk_req = 2'b11;
        @(negedge clk);
        chk("R3 tie after core 0 goes to core 1", lk_gnt, 2'b10);
        lk_req[1] = 1'b0;
        wait_done(1, n);
        wait_gnt(0, n);
        wait_done(0, n);
    endtask

    task automatic t_bits();
        logic [DW-1:0] o, d; logic cf, sf;
        plain_wr(0, 4'd3, 32'h0000_0100);
        lock_op(1, 3'd0, 4'd3, 5'd3, '0, o, cf, sf);
        chk("R7 set on clear bit carry", cf, 0);
        chk("R13 set old value", o, 32'h0000_0100);
        chk("R7 set sign zero", sf, 0);
        lock_op(0, 3'd0, 4'd3, 5'd3, '0, o, cf, sf);
        chk("R7 set on set bit carry", cf, 1);
        plain_rd(0, 4'd3, d);
        chk("R7 word after set", d, 32'h0000_0108);
        lock_op(0, 3'd1, 4'd3, 5'd8, '0, o, cf, sf);
        chk("R8 clear on set bit carry", cf, 1);
        lock_op(1, 3'd1, 4'd3, 5'd31, '0, o, cf, sf);
        chk("R8 clear on clear bit carry", cf, 0);
        chk("R8 clear old value", o, 32'h0000_0008);
        plain_rd(1, 4'd3, d);
        chk("R8 word after clear", d, 32'h0000_0008);
    endtask

    task automatic t_arith();
        logic [DW-1:0] o, d; logic cf, sf;
        plain_wr(1, 4'd2, 32'd1);
        lock_op(0, 3'd2, 4'd2, '0, '0, o, cf, sf);
        chk("R9 dec 1 old", o, 1);
        chk("R9 dec to zero sign", sf, 0);
        lock_op(0, 3'd2, 4'd2, '0, '0, o, cf, sf);
        chk("R9 dec below zero sign", sf, 1);
        chk("R9 dec carry zero", cf, 0);
        plain_rd(0, 4'd2, d);
        chk("R9 dec wraps", d, 32'hFFFF_FFFF);
        lock_op(1, 3'd3, 4'd2, '0, '0, o, cf, sf);
        chk("R10 inc old", o, 32'hFFFF_FFFF);
        chk("R10 inc to zero sign", sf, 0);
        plain_wr(0, 4'd2, 32'h7FFF_FFFF);
        lock_op(1, 3'd3, 4'd2, '0, '0, o, cf, sf);
        chk("R10 inc across sign boundary", sf, 1);
        plain_rd(1, 4'd2, d);
        chk("R10 inc result", d, 32'h8000_0000);
    endtask

    task automatic t_swap_bad();
        logic [DW-1:0] o, d; logic cf, sf;
        plain_wr(0, 4'd5, 32'hDEAD_BEEF);
        lock_op(1, 3'd4, 4'd5, 5'd7, 32'h0123_4567, o, cf, sf);
        chk("R11 swap returns prior", o, 32'hDEAD_BEEF);
        chk("R11 swap flags", {cf, sf}, 0);
        plain_rd(0, 4'd5, d);
        chk("R11 swap wrote value", d, 32'h0123_4567);
        for (int k = 5; k < 8; k++) begin
            lock_op(0, 3'(k), 4'd5, 5'd0, 32'hFFFF_FFFF, o, cf, sf);
            chk("R12 unused code old", o, 32'h0123_4567);
            chk("R12 unused code flags", {cf, sf}, 0);
        end
        plain_rd(1, 4'd5, d);
        chk("R12 word untouched", d, 32'h0123_4567);
    endtask

    task automatic t_drain();
        int n;
        logic [DW-1:0] d;
        plain_wr(0, 4'd6, 32'h0000_0001);
        @(negedge clk);
        sb_empty[0] = 1'b0;
        lk_req[0] = 1'b1; lk_op[0] = 3'd0; lk_addr[0] = 4'd6; lk_bit[0] = 5'd5;
        wait_gnt(0, n);
        // Execute cycle: both cores' plain accesses held.
        pl_vld = 2'b11; pl_we = 2'b01;
        pl_addr[0] = 4'd7; pl_wdata[0] = 32'h7777_7777;
        pl_addr[1] = 4'd6;
        #1;
        chk("R6 owner stalled in execute", pl_stall[0], 1);
        chk("R5 other stalled in execute", pl_stall[1], 1);
        @(negedge clk);
        chk("R6 owner served in drain", pl_stall[0], 0);
        chk("R5 other stalled in drain", pl_stall[1], 1);
        @(negedge clk);
        pl_vld[0] = 1'b0; pl_we[0] = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R6 no done while buffer busy", lk_done, 0);
            chk("R5 other still stalled", pl_stall[1], 1);
            @(negedge clk);
        end
        sb_empty[0] = 1'b1;
        @(negedge clk);
        chk("R6 done after buffer empty", lk_done, 2'b01);
        chk("R5 stall lifts at done", pl_stall[1], 0);
        @(negedge clk);
        pl_vld[1] = 1'b0;
        chk("R5 stalled read sees locked result", pl_rdata[1], 32'h0000_0021);
        plain_rd(1, 4'd7, d);
        chk("R6 drain store visible", d, 32'h7777_7777);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_rr();
        t_plain();
        t_bits();
        t_arith();
        t_swap_bad();
        t_drain();
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule